// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the control sequencer of a small multicycle RV32 integer core whose datapath has a single shared memory for instructions and data and a single ALU. Every addition goes through that ALU, including the program-counter increment. The controller takes the opcode, funct3 and bit 5 of funct7 of the instruction held in the instruction register, plus the ALU zero flag. Each cycle it drives the memory address select, the write enables for the instruction register, the PC, the memory and the register file, the two ALU operand selects, the ALU operation and the result select. The datapath registers are outside the block. They are OldPC, ALUOut, Data, and the A/B operand registers.

Instructions take a variable number of states. These are the state names and transitions:

- Every instruction starts with FETCH → DECODE.
- A load runs DECODE → MEM_ADDR → MEM_READ → LOAD_WB → FETCH.
- A store runs DECODE → MEM_ADDR → MEM_WRITE → FETCH.
- A register-register operation runs DECODE → EXEC_REG → ALU_WB → FETCH.
- A register-immediate operation runs DECODE → EXEC_IMM → ALU_WB → FETCH.
- A branch-if-equal runs DECODE → BRANCH → FETCH.
- A jump-and-link runs DECODE → JUMP → ALU_WB → FETCH.
- An opcode outside this set goes from DECODE back to FETCH.

As a result, a load takes 5 cycles, a branch 3, and the other instructions 4.

Top module: `mcyc_ctrl`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge puts the controller in FETCH for the following cycle, whatever state it was in and whatever opcode is present.
- R2: In FETCH, the controller reads the memory at the PC (`addr_sel`=0 selects PC, 1 selects ALUOut) and asserts `ir_we` and `pc_we`. The ALU computes PC+4: `alu_a_sel`=0 (PC), `alu_b_sel`=2 (constant 4), `alu_op`=0 (add). `res_sel`=2 (direct ALU result) is the PC source.
- R3: In DECODE, no write enable is asserted. The ALU forms OldPC+imm as the branch target (`alu_a_sel`=1, `alu_b_sel`=1 immediate, add). An opcode that is not among the six supported ones returns to FETCH after DECODE.
- R4: A load (opcode 0000011) passes through three states. In MEM_ADDR, the ALU adds register A and the immediate (`alu_a_sel`=2, `alu_b_sel`=1, add). In MEM_READ, the memory is read at ALUOut with `addr_sel`=1 and `res_sel`=0. In LOAD_WB, the controller asserts `rf_we` with `res_sel`=1 (Data register). It then returns to FETCH.
- R5: A store (opcode 0100011) uses MEM_ADDR, then MEM_WRITE. MEM_WRITE asserts `mem_we` with `addr_sel`=1, and the controller then returns to FETCH.
- R6: A register-register operation (opcode 0110011) runs EXEC_REG with `alu_a_sel`=2 and `alu_b_sel`=0 (register B). It then runs ALU_WB, which asserts `rf_we` with `res_sel`=0. The `alu_op` codes are 0 add, 1 subtract, 2 and, 3 or, 4 set-less-than. They are chosen by funct3: 000 gives add, or subtract when the funct7 bit is 1; 111 gives and; 110 gives or; 010 gives set-less-than. Any other funct3 gives add.
- R7: A register-immediate operation (opcode 0010011) runs EXEC_IMM with `alu_b_sel`=1 and then ALU_WB. It uses the same funct3 mapping as R6, except that the funct7 bit is ignored, so funct3 000 always adds.
- R8: A branch-if-equal (opcode 1100011) runs BRANCH, which subtracts register B from register A (`alu_a_sel`=2, `alu_b_sel`=0, `alu_op`=1) with `res_sel`=0. In BRANCH, `pc_we` equals `zero`. The controller then returns to FETCH.
- R9: A jump-and-link (opcode 1101111) runs JUMP, which asserts `pc_we` with `res_sel`=0 to load the target held in ALUOut. In the same state, the ALU forms OldPC+4 (`alu_a_sel`=1, `alu_b_sel`=2, add). The controller then goes to ALU_WB, which writes that value to rd.
- R10: Every select or operation field that a state does not use is driven to 0. At most one of `ir_we`, `mem_we` and `rf_we` is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 7 | Opcode field of the held instruction |
| funct3 | input | 3 | funct3 field of the held instruction |
| funct7_b5 | input | 1 | Bit 5 of funct7 |
| zero | input | 1 | ALU zero flag |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALUOut |
| ir_we | output | 1 | Instruction register write (OldPC captured too) |
| pc_we | output | 1 | PC update enable |
| alu_a_sel | output | 2 | ALU A: 0 PC, 1 OldPC, 2 register A |
| alu_b_sel | output | 2 | ALU B: 0 register B, 1 immediate, 2 constant 4 |
| alu_op | output | 3 | 0 add, 1 sub, 2 and, 3 or, 4 slt |
| mem_we | output | 1 | Memory write enable |
| rf_we | output | 1 | Register file write enable |
| res_sel | output | 2 | Result: 0 ALUOut, 1 Data, 2 ALU result |

## Verification
Every supported instruction class is driven through its full state sequence, back to back, and the bench compares every output in every cycle.

- The load and store share MEM_ADDR, so they show whether the controller branches on the opcode after that state.
- Register-register and register-immediate operations are each run with all four funct3 codes. The funct7 bit is set on both kinds, which separates subtract from add and shows that the immediate path ignores the bit.
- The branch is run with `zero` low and high to show that `pc_we` follows the flag.
- An unknown opcode and a reset in the middle of a load check the two ways back to FETCH that do not come from a finished instruction.

// File: rtl/mcyc_ctrl_pkg.sv
`timescale 1ns/1ps
package mcyc_ctrl_pkg;

    localparam int OPC_W   = 7;
    localparam int F3_W    = 3;
    localparam int ASEL_W  = 2;
    localparam int BSEL_W  = 2;
    localparam int AOP_W   = 3;
    localparam int RSEL_W  = 2;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_REG   = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_IMM   = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_JAL   = 7'b1101111;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_MEM_ADDR, ST_MEM_READ, ST_LOAD_WB,
        ST_MEM_WRITE, ST_EXEC_REG, ST_EXEC_IMM, ST_ALU_WB, ST_BRANCH, ST_JUMP
    } state_t;

    typedef enum logic [2:0] {
        CL_LOAD, CL_STORE, CL_REG, CL_IMM, CL_BEQ, CL_JAL, CL_OTHER
    } iclass_t;

    typedef enum logic [AOP_W-1:0] {
        AOP_ADD = 3'd0, AOP_SUB = 3'd1, AOP_AND = 3'd2, AOP_OR = 3'd3, AOP_SLT = 3'd4
    } aop_t;

    typedef enum logic [ASEL_W-1:0] {
        A_PC = 2'd0, A_OLDPC = 2'd1, A_REG = 2'd2
    } asel_t;

    typedef enum logic [BSEL_W-1:0] {
        B_REG = 2'd0, B_IMM = 2'd1, B_FOUR = 2'd2
    } bsel_t;

    typedef enum logic [RSEL_W-1:0] {
        R_ALUOUT = 2'd0, R_DATA = 2'd1, R_ALU = 2'd2
    } rsel_t;

endpackage

// File: rtl/mcyc_opdec.sv
`timescale 1ns/1ps
module mcyc_opdec
    import mcyc_ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output iclass_t          iclass
);
    always_comb begin
        unique case (opcode)
            OPC_LOAD:  iclass = CL_LOAD;
            OPC_STORE: iclass = CL_STORE;
            OPC_REG:   iclass = CL_REG;
            OPC_IMM:   iclass = CL_IMM;
            OPC_BEQ:   iclass = CL_BEQ;
            OPC_JAL:   iclass = CL_JAL;
            default:   iclass = CL_OTHER;
        endcase
    end
endmodule

// File: rtl/mcyc_aludec.sv
`timescale 1ns/1ps
module mcyc_aludec
    import mcyc_ctrl_pkg::*;
(
    input  logic [F3_W-1:0] funct3,
    input  logic            funct7_b5,
    input  logic            is_reg,
    output aop_t            func_op
);
    always_comb begin
        unique case (funct3)
            3'b000:  func_op = (is_reg && funct7_b5) ? AOP_SUB : AOP_ADD;
            3'b111:  func_op = AOP_AND;
            3'b110:  func_op = AOP_OR;
            3'b010:  func_op = AOP_SLT;
            default: func_op = AOP_ADD;
        endcase
    end
endmodule

// File: rtl/mcyc_seq.sv
`timescale 1ns/1ps
module mcyc_seq
    import mcyc_ctrl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  iclass_t iclass,
    output state_t  state
);
    state_t next;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= next;
    end

    always_comb begin
        next = ST_FETCH;
        unique case (state)
            ST_FETCH:     next = ST_DECODE;
            ST_DECODE: begin
                unique case (iclass)
                    CL_LOAD, CL_STORE: next = ST_MEM_ADDR;
                    CL_REG:            next = ST_EXEC_REG;
                    CL_IMM:            next = ST_EXEC_IMM;
                    CL_BEQ:            next = ST_BRANCH;
                    CL_JAL:            next = ST_JUMP;
                    default:           next = ST_FETCH;
                endcase
            end
            ST_MEM_ADDR:  next = (iclass == CL_LOAD) ? ST_MEM_READ : ST_MEM_WRITE;
            ST_MEM_READ:  next = ST_LOAD_WB;
            ST_LOAD_WB:   next = ST_FETCH;
            ST_MEM_WRITE: next = ST_FETCH;
            ST_EXEC_REG:  next = ST_ALU_WB;
            ST_EXEC_IMM:  next = ST_ALU_WB;
            ST_ALU_WB:    next = ST_FETCH;
            ST_BRANCH:    next = ST_FETCH;
            ST_JUMP:      next = ST_ALU_WB;
            default:      next = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcyc_outdec.sv
`timescale 1ns/1ps
module mcyc_outdec
    import mcyc_ctrl_pkg::*;
(
    input  state_t state,
    input  aop_t   func_op,
    input  logic   zero,
    output logic   addr_sel,
    output logic   ir_we,
    output logic   pc_we,
    output asel_t  a_sel,
    output bsel_t  b_sel,
    output aop_t   op,
    output logic   mem_we,
    output logic   rf_we,
    output rsel_t  res_sel
);
    always_comb begin
        addr_sel = 1'b0;
        ir_we    = 1'b0;
        pc_we    = 1'b0;
        a_sel    = A_PC;
        b_sel    = B_REG;
        op       = AOP_ADD;
        mem_we   = 1'b0;
        rf_we    = 1'b0;
        res_sel  = R_ALUOUT;
        unique case (state)
            ST_FETCH: begin
                ir_we   = 1'b1;
                pc_we   = 1'b1;
                b_sel   = B_FOUR;
                res_sel = R_ALU;
            end
            ST_DECODE: begin
                a_sel = A_OLDPC;
                b_sel = B_IMM;
            end
            ST_MEM_ADDR: begin
                a_sel = A_REG;
                b_sel = B_IMM;
            end
            ST_MEM_READ: begin
                addr_sel = 1'b1;
            end
            ST_LOAD_WB: begin
                rf_we   = 1'b1;
                res_sel = R_DATA;
            end
            ST_MEM_WRITE: begin
                addr_sel = 1'b1;
                mem_we   = 1'b1;
            end
            ST_EXEC_REG: begin
                a_sel = A_REG;
                op    = func_op;
            end
            ST_EXEC_IMM: begin
                a_sel = A_REG;
                b_sel = B_IMM;
                op    = func_op;
            end
            ST_ALU_WB: begin
                rf_we = 1'b1;
            end
            ST_BRANCH: begin
                a_sel = A_REG;
                op    = AOP_SUB;
                pc_we = zero;
            end
            ST_JUMP: begin
                pc_we = 1'b1;
                a_sel = A_OLDPC;
                b_sel = B_FOUR;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mcyc_ctrl.sv
`timescale 1ns/1ps
module mcyc_ctrl
    import mcyc_ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [OPC_W-1:0]    opcode,
    input  logic [F3_W-1:0]     funct3,
    input  logic                funct7_b5,
    input  logic                zero,
    output logic                addr_sel,
    output logic                ir_we,
    output logic                pc_we,
    output logic [ASEL_W-1:0]   alu_a_sel,
    output logic [BSEL_W-1:0]   alu_b_sel,
    output logic [AOP_W-1:0]    alu_op,
    output logic                mem_we,
    output logic                rf_we,
    output logic [RSEL_W-1:0]   res_sel
);
    iclass_t iclass;
    state_t  state;
    aop_t    func_op;
    asel_t   a_sel;
    bsel_t   b_sel;
    aop_t    op;
    rsel_t   rsel;

    mcyc_opdec u_opdec (
        .opcode (opcode),
        .iclass (iclass)
    );

    mcyc_aludec u_aludec (
        .funct3    (funct3),
        .funct7_b5 (funct7_b5),
        .is_reg    (iclass == CL_REG),
        .func_op   (func_op)
    );

    mcyc_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .iclass (iclass),
        .state  (state)
    );

    mcyc_outdec u_outdec (
        .state    (state),
        .func_op  (func_op),
        .zero     (zero),
        .addr_sel (addr_sel),
        .ir_we    (ir_we),
        .pc_we    (pc_we),
        .a_sel    (a_sel),
        .b_sel    (b_sel),
        .op       (op),
        .mem_we   (mem_we),
        .rf_we    (rf_we),
        .res_sel  (rsel)
    );

    assign alu_a_sel = a_sel;
    assign alu_b_sel = b_sel;
    assign alu_op    = op;
    assign res_sel   = rsel;
endmodule

// File: rtl/mcyc_ctrl_chk.sv
`timescale 1ns/1ps
module mcyc_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [6:0] opcode,
    input logic [2:0] funct3,
    input logic       funct7_b5,
    input logic       zero,
    input logic       addr_sel,
    input logic       ir_we,
    input logic       pc_we,
    input logic [1:0] alu_a_sel,
    input logic [1:0] alu_b_sel,
    input logic [2:0] alu_op,
    input logic       mem_we,
    input logic       rf_we,
    input logic [1:0] res_sel
);
    a_r1_reset_fetch: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ir_we && pc_we));

    a_r2_fetch_pc_addr: assert property (@(posedge clk) disable iff (rst)
        ir_we |-> (pc_we && !addr_sel && alu_b_sel == 2'd2 && res_sel == 2'd2));

    a_r3_decode_quiet: assert property (@(posedge clk) disable iff (rst)
        ir_we |=> (!ir_we && !pc_we && !mem_we && !rf_we));

    a_r4_load_wb_after_read: assert property (@(posedge clk) disable iff (rst)
        (rf_we && res_sel == 2'd1) |-> $past(addr_sel && !mem_we));

    a_r5_store_at_aluout: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> addr_sel);

    a_r5_store_then_fetch: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> ir_we);

    a_r8_branch_on_zero: assert property (@(posedge clk) disable iff (rst)
        (pc_we && !ir_we && alu_op == 3'd1) |-> zero);

    a_r10_one_write: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ir_we, mem_we, rf_we}));

    a_r10_rf_then_fetch: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> ir_we);
endmodule

bind mcyc_ctrl mcyc_ctrl_chk u_chk (.*);

// File: tb/mcyc_ctrl_test.sv
`timescale 1ns/1ps
module mcyc_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] opcode = 7'b0110011;
    logic [2:0] funct3 = 3'b000;
    logic       funct7_b5 = 1'b0;
    logic       zero = 1'b0;
    logic       addr_sel, ir_we, pc_we, mem_we, rf_we;
    logic [1:0] alu_a_sel, alu_b_sel, res_sel;
    logic [2:0] alu_op;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [13:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    mcyc_ctrl uut (
        .clk(clk), .rst(rst), .opcode(opcode), .funct3(funct3),
        .funct7_b5(funct7_b5), .zero(zero), .addr_sel(addr_sel),
        .ir_we(ir_we), .pc_we(pc_we), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .alu_op(alu_op), .mem_we(mem_we),
        .rf_we(rf_we), .res_sel(res_sel)
    );

    // packing: addr ir pc a[2] b[2] op[3] mem rf res[2]
    function automatic logic [13:0] mk(input logic ad, input logic ir, input logic pc,
                                       input logic [1:0] a, input logic [1:0] b,
                                       input logic [2:0] op, input logic mw,
                                       input logic rw, input logic [1:0] rs);
        return {ad, ir, pc, a, b, op, mw, rw, rs};
    endfunction

    localparam logic [2:0] ADD = 3'd0, SUB = 3'd1, AND_ = 3'd2, OR_ = 3'd3, SLT = 3'd4;

    function automatic logic [13:0] v_fetch();  return mk(0,1,1,2'd0,2'd2,ADD,0,0,2'd2); endfunction
    function automatic logic [13:0] v_decode(); return mk(0,0,0,2'd1,2'd1,ADD,0,0,2'd0); endfunction
    function automatic logic [13:0] v_madr();   return mk(0,0,0,2'd2,2'd1,ADD,0,0,2'd0); endfunction
    function automatic logic [13:0] v_mread();  return mk(1,0,0,2'd0,2'd0,ADD,0,0,2'd0); endfunction
    function automatic logic [13:0] v_lwb();    return mk(0,0,0,2'd0,2'd0,ADD,0,1,2'd1); endfunction
    function automatic logic [13:0] v_mwrite(); return mk(1,0,0,2'd0,2'd0,ADD,1,0,2'd0); endfunction
    function automatic logic [13:0] v_awb();    return mk(0,0,0,2'd0,2'd0,ADD,0,1,2'd0); endfunction
    function automatic logic [13:0] v_jump();   return mk(0,0,1,2'd1,2'd2,ADD,0,0,2'd0); endfunction

    task automatic step(input logic [13:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
    endtask

    task automatic set_in(input logic [6:0] o, input logic [2:0] f3, input logic f7, input logic z);
        opcode = o; funct3 = f3; funct7_b5 = f7; zero = z;
    endtask

    task automatic run_load();
        set_in(7'b0000011, 3'b010, 1'b0, 1'b0);
        step(v_fetch(), "R2"); step(v_decode(), "R3");
        step(v_madr(), "R4"); step(v_mread(), "R4"); step(v_lwb(), "R4");
    endtask

    task automatic run_store();
        set_in(7'b0100011, 3'b010, 1'b0, 1'b0);
        step(v_fetch(), "R2"); step(v_decode(), "R3");
        step(v_madr(), "R5"); step(v_mwrite(), "R5");
    endtask

    task automatic run_reg(input logic [2:0] f3, input logic f7, input logic [2:0] op);
        set_in(7'b0110011, f3, f7, 1'b0);
        step(v_fetch(), "R2"); step(v_decode(), "R3");
        step(mk(0,0,0,2'd2,2'd0,op,0,0,2'd0), "R6"); step(v_awb(), "R6");
    endtask

    task automatic run_imm(input logic [2:0] f3, input logic f7, input logic [2:0] op);
        set_in(7'b0010011, f3, f7, 1'b0);
        step(v_fetch(), "R2"); step(v_decode(), "R3");
        step(mk(0,0,0,2'd2,2'd1,op,0,0,2'd0), "R7"); step(v_awb(), "R7");
    endtask

    task automatic run_beq(input logic z);
        set_in(7'b1100011, 3'b000, 1'b0, z);
        step(v_fetch(), "R2"); step(v_decode(), "R3");
        step(mk(0,0,z,2'd2,2'd0,SUB,0,0,2'd0), "R8");
    endtask

    task automatic run_jal();
        set_in(7'b1101111, 3'b000, 1'b0, 1'b0);
        step(v_fetch(), "R2"); step(v_decode(), "R3");
        step(v_jump(), "R9"); step(v_awb(), "R9");
    endtask

    // monitor: compares every output in every cycle (R10 covered by full-vector match)
    always @(negedge clk) begin
        if (!done && exp_q.size() > 0) begin
            logic [13:0] e;
            logic [13:0] a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {addr_sel, ir_we, pc_we, alu_a_sel, alu_b_sel, alu_op, mem_we, rf_we, res_sel};
            n_checks++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s/R10: outputs %b expected %b at %0t", t, a, e, $time);
            end
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cycles %0d expected below %0d", wd, 20000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset with a register-register opcode present keeps FETCH
        @(posedge clk); #1;
        step(v_fetch(), "R1");
        rst = 1'b0;
        run_load();
        run_store();
        run_reg(3'b000, 1'b0, ADD);
        run_reg(3'b000, 1'b1, SUB);
        run_reg(3'b111, 1'b0, AND_);
        run_reg(3'b110, 1'b1, OR_);
        run_reg(3'b010, 1'b0, SLT);
        run_reg(3'b001, 1'b0, ADD);
        run_imm(3'b000, 1'b1, ADD);
        run_imm(3'b111, 1'b0, AND_);
        run_imm(3'b110, 1'b0, OR_);
        run_imm(3'b010, 1'b1, SLT);
        run_beq(1'b0);
        run_beq(1'b1);
        run_jal();
        // R3: unsupported opcode goes back to FETCH after DECODE
        set_in(7'b1111111, 3'b000, 1'b0, 1'b0);
        step(v_fetch(), "R2"); step(v_decode(), "R3");
        // R1: reset in the middle of a load
        set_in(7'b0000011, 3'b010, 1'b0, 1'b0);
        step(v_fetch(), "R2"); step(v_decode(), "R3");
        rst = 1'b1;
        step(v_madr(), "R4");
        rst = 1'b0;
        step(v_fetch(), "R1");
        step(v_decode(), "R1");
        step(v_madr(), "R4"); step(v_mread(), "R4"); step(v_lwb(), "R4");
        run_jal();
        run_store();
        step(v_fetch(), "R2");
        @(negedge clk); #1;
        if (exp_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL scoreboard: %0d items left expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule